// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit sits inside a 16550-style serial port. It holds the modem control byte and builds the modem status byte from it. When the control byte's loopback bit is set, the four control outputs feed straight back into the four status line bits, so software can test its modem handling without any external wiring. When loopback is clear, the status lines report a fixed idle state.

Each write to the control byte compares the old status line levels with the new ones. Any change sets a sticky delta bit in the low half of the status byte. The delta bits build up over any number of writes and are cleared only when software reads the status byte. Their OR is driven out as `delta_pend` for the interrupt controller. Both bytes are read through one registered read-data port, which uses one strobe per register.

Top module: `mdm_unit`

## Requirements
- R1: A control write stores `ctl_wr_data[4:0]` into `ctl_q[4:0]`. `ctl_q[7:5]` always reads zero. The control byte changes only on a write.
- R2: When `ctl_q[4]` (loopback) is 1, the status line bits follow the control bits: `sts_q[4]`=`ctl_q[1]`, `sts_q[5]`=`ctl_q[0]`, `sts_q[6]`=`ctl_q[2]` and `sts_q[7]`=`ctl_q[3]`.
- R3: When `ctl_q[4]` is 0, `sts_q[7:4]` equals 4'b1010: `sts_q[7]` and `sts_q[5]` are 1, and `sts_q[6]` and `sts_q[4]` are 0.
- R4: On a control write, each change of a line bit sets its delta bit. A change of `sts_q[4]` sets `sts_q[0]`, a change of `sts_q[5]` sets `sts_q[1]`, and a change of `sts_q[7]` sets `sts_q[3]`. The new value is visible in the cycle after the write.
- R5: `sts_q[2]` is set only when `sts_q[6]` falls from 1 to 0 on a write. A rise of `sts_q[6]` sets no delta bit.
- R6: Without a status read, delta bits stay set across later writes and idle cycles, while `sts_q[7:4]` tracks the control byte.
- R7: A status read strobe returns the full status byte on `rd_data` in the next cycle and clears `sts_q[3:0]` in that same cycle.
- R8: When a write and a status read happen in the same cycle, the read returns the status as it was before both. Afterwards the delta bits hold only the changes caused by that write.
- R9: `delta_pend` is 1 exactly when any of `sts_q[3:0]` is 1.
- R10: After reset, `ctl_q` is 0x00, `sts_q` is 0xA0, `delta_pend` is 0 and `rd_data` is 0x00.
- R11: A control read strobe returns `ctl_q` on `rd_data` in the next cycle and leaves the delta bits unchanged. When both strobes are high, the status byte is returned and the delta bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_en | input | 1 | Write strobe for the control byte |
| ctl_wr_data | input | 8 | Control byte write data |
| ctl_rd_en | input | 1 | Read strobe for the control byte |
| sts_rd_en | input | 1 | Read strobe for the status byte (clears the delta bits) |
| ctl_q | output | 8 | Current control byte |
| sts_q | output | 8 | Current status byte |
| delta_pend | output | 1 | At least one delta bit is set |
| rd_data | output | 8 | Registered read data |

## Verification
A write or a status read takes effect at the clock edge where its strobe is sampled. `ctl_q`, `sts_q` and `delta_pend` therefore show the result one cycle after the strobe, and `rd_data` carries the returned byte in that same cycle. The bench drives strobes just after a rising edge and updates its reference model at the next rising edge. It compares the live outputs at every falling edge. Expected read bytes go into a queue when a strobe is issued, and the monitor takes them out at the first falling edge after the capturing edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W   = 8;
  localparam int CTL_W   = 5;
  localparam int NIB_W   = REG_W / 2;
  localparam int LOOP_IX = CTL_W - 1;

  // line levels; packed order places dcd in status bit 7 and cts in bit 4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  localparam line_t IDLE_LINES = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};

  function automatic logic [CTL_W-1:0] ctl_mask(input logic [REG_W-1:0] raw);
    return raw[CTL_W-1:0];
  endfunction

  function automatic line_t lines_of(input logic [CTL_W-1:0] c);
    line_t l;
    if (c[LOOP_IX]) begin
      l.cts = c[1];
      l.dsr = c[0];
      l.ri  = c[2];
      l.dcd = c[3];
    end else begin
      l = IDLE_LINES;
    end
    return l;
  endfunction

  function automatic logic [NIB_W-1:0] change_of(input line_t o, input line_t n);
    logic [NIB_W-1:0] d;
    d[0] = o.cts ^ n.cts;
    d[1] = o.dsr ^ n.dsr;
    d[2] = o.ri & ~n.ri;
    d[3] = o.dcd ^ n.dcd;
    return d;
  endfunction
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CTL_W-1:0] ctl_next_o
);
  assign ctl_next_o = wr_en ? ctl_mask(wr_data) : ctl_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_o <= '0;
    else        ctl_o <= ctl_next_o;
  end
endmodule

// File: rtl/mdm_line_map.sv
module mdm_line_map
  import mdm_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  output line_t            lines_o
);
  assign lines_o = lines_of(ctl_i);
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NIB_W-1:0] chg,
  output logic [NIB_W-1:0] delta_o,
  output logic             pend_o
);
  logic [NIB_W-1:0] kept;

  assign kept = clr ? '0 : delta_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta_o <= '0;
    else        delta_o <= kept | chg;
  end

  assign pend_o = |delta_o;
endmodule

// File: rtl/mdm_read_port.sv
module mdm_read_port
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_rd,
  input  logic             sts_rd,
  input  logic [REG_W-1:0] ctl_val,
  input  logic [REG_W-1:0] sts_val,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (sts_rd) rd_data <= sts_val;
    else if (ctl_rd) rd_data <= ctl_val;
  end
endmodule

// File: rtl/mdm_unit.sv
module mdm_unit
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  input  logic             ctl_rd_en,
  input  logic             sts_rd_en,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] sts_q,
  output logic             delta_pend,
  output logic [REG_W-1:0] rd_data
);
  logic [CTL_W-1:0] ctl_cur, ctl_nxt;
  line_t            lines_cur, lines_nxt;
  logic [NIB_W-1:0] chg_bits, delta_bits;
  logic             wr_event, clr_event;

  assign wr_event  = ctl_wr_en;
  assign clr_event = sts_rd_en;

  mdm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_event), .wr_data(ctl_wr_data),
    .ctl_o(ctl_cur), .ctl_next_o(ctl_nxt)
  );

  mdm_line_map u_map_cur (.ctl_i(ctl_cur), .lines_o(lines_cur));
  mdm_line_map u_map_nxt (.ctl_i(ctl_nxt), .lines_o(lines_nxt));

  assign chg_bits = wr_event ? change_of(lines_cur, lines_nxt) : '0;

  mdm_delta_track u_delta (
    .clk(clk), .rst_n(rst_n), .clr(clr_event), .chg(chg_bits),
    .delta_o(delta_bits), .pend_o(delta_pend)
  );

  assign ctl_q = {{(REG_W-CTL_W){1'b0}}, ctl_cur};
  assign sts_q = {lines_cur, delta_bits};

  mdm_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .ctl_rd(ctl_rd_en), .sts_rd(sts_rd_en),
    .ctl_val(ctl_q), .sts_val(sts_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdm_unit_chk.sv
module mdm_unit_chk
  import mdm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr_en,
  input logic [REG_W-1:0] ctl_wr_data,
  input logic             ctl_rd_en,
  input logic             sts_rd_en,
  input logic [REG_W-1:0] ctl_q,
  input logic [REG_W-1:0] sts_q,
  input logic             delta_pend,
  input logic [REG_W-1:0] rd_data
);
  // R1
  ctl_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[REG_W-1:CTL_W] == '0);
  // R1
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_q));
  // R2
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[LOOP_IX] |-> (sts_q[7:4] == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]}));
  // R3
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[LOOP_IX] |-> (sts_q[7:4] == 4'b1010));
  // R6
  delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd_en |=> ((sts_q[3:0] & $past(sts_q[3:0])) == $past(sts_q[3:0])));
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd_en && !ctl_wr_en) |=> (sts_q[3:0] == '0));
  // R7
  read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd_en |=> (rd_data == $past(sts_q)));
  // R9
  pend_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delta_pend == (sts_q[3:0] != '0));
  // R11
  ctl_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_en && !sts_rd_en && !ctl_wr_en) |=> $stable(sts_q[3:0]));
endmodule

bind mdm_unit mdm_unit_chk chk_i (.*);

// File: tb/mdm_unit_test.sv
module mdm_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_data = 8'h00;
  logic       ctl_rd_en = 1'b0;
  logic       sts_rd_en = 1'b0;
  logic [7:0] ctl_q, sts_q, rd_data;
  logic       delta_pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit run_mon = 1'b0;
  bit rd_seen = 1'b0;

  logic [4:0] m_ctl = '0;
  logic [3:0] m_delta = '0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  mdm_unit uut (.*);

  // bench reference: {dcd, ri, dsr, cts}
  function automatic logic [3:0] ref_lines(input logic [4:0] c);
    if (!c[4]) return 4'b1010;
    return {c[3], c[2], c[0], c[1]};
  endfunction

  function automatic logic [3:0] ref_chg(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] x;
    x = o ^ n;
    return {x[3], o[2] & ~n[2], x[1], x[0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(input bit wr, input logic [7:0] wd, input bit crd, input bit srd);
    logic [4:0] nctl;
    ctl_wr_en = wr; ctl_wr_data = wd; ctl_rd_en = crd; sts_rd_en = srd;
    if (srd) exp_q.push_back({ref_lines(m_ctl), m_delta});
    else if (crd) exp_q.push_back({3'b000, m_ctl});
    @(posedge clk);
    nctl = wr ? wd[4:0] : m_ctl;
    m_delta = (srd ? 4'b0 : m_delta) | (wr ? ref_chg(ref_lines(m_ctl), ref_lines(nctl)) : 4'b0);
    m_ctl = nctl;
    #2;
    ctl_wr_en = 1'b0; ctl_rd_en = 1'b0; sts_rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  always @(posedge clk) rd_seen <= ctl_rd_en | sts_rd_en;

  // monitor: live outputs against the model, read data against the queue
  initial begin
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (run_mon) begin
        check("R1 ctl_q", ctl_q, {3'b000, m_ctl});
        check("R2/R3/R4/R5/R6 sts_q", sts_q, {ref_lines(m_ctl), m_delta});
        check("R9 delta_pend", {7'b0, delta_pend}, {7'b0, |m_delta});
        if (rd_seen) begin
          if (exp_q.size() == 0) check("R7/R11 rd_data unexpected", rd_data, 8'hxx);
          else check("R7/R8/R11 rd_data", rd_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check("R10 ctl_q", ctl_q, 8'h00);
    check("R10 sts_q", sts_q, 8'hA0);
    check("R10 delta_pend", {7'b0, delta_pend}, 8'h00);
    check("R10 rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    run_mon = 1'b1;
    idle(2);
    op(0, 8'h00, 0, 1);             // R7 clean read
    op(1, 8'hE3, 0, 0);             // R1 masking, loopback off: no deltas (R3)
    idle(1);
    op(0, 8'h00, 1, 0);             // R11 ctl read
    op(1, 8'h10, 0, 0);             // R2/R4 loopback all low: DSR, DCD change
    op(1, 8'h10, 0, 0);             // R6 same value keeps deltas
    idle(2);
    op(0, 8'h00, 1, 0);             // R11 ctl read keeps deltas
    op(0, 8'h00, 0, 1);             // R7 read and clear
    op(1, 8'h14, 0, 0);             // R5 ring rises: no trailing bit
    op(1, 8'h10, 0, 0);             // R5 ring falls: trailing bit
    op(1, 8'h1F, 0, 1);             // R8 write with read
    op(0, 8'h00, 0, 1);
    op(1, 8'h1E, 0, 0);             // R4 dsr change only
    op(1, 8'h1C, 0, 0);             // R4 cts change, R6 accumulate
    op(1, 8'h18, 0, 0);             // R5 ring falls
    op(0, 8'h00, 1, 1);             // R11 both strobes: status wins and clears
    op(1, 8'h00, 0, 0);             // leave loopback: R3
    op(0, 8'h00, 0, 1);
    op(1, 8'hFF, 0, 0);             // R1 upper bits dropped
    op(1, 8'h0F, 1, 0);             // R11 ctl read with write returns old value
    idle(2);
    op(0, 8'h00, 0, 1);
    idle(2);
    if (exp_q.size() != 0) check("R7 pending reads", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule